// File: doc/BRIEF.md
# Prescaled Compare Event Timer

This block is one 16-bit timer channel with a four-word register port. A slow reference enable pulse drives a power-of-two prescaler. The prescaler produces count ticks, and the counter advances by one on each tick. Two compare registers are checked against the value the counter is about to take. A match sets a sticky flag. Comparator 2 can also return the counter to zero, which gives periodic or one-shot events. Each comparator drives an event output while its flag is set and its mode selects event generation.

Software programs the compare values, clears the counter and then writes the setup word once. The scale and mode fields lock on that first setup write. Later setup writes only start or stop the counter and acknowledge flags. One write can stop the counter and clear both flags in the same cycle.

Top module: `evtimer`

## Requirements
- R1: After reset, all four registers read 0 and both event outputs are low.
- R2: Register addresses are 0 for compare 1, 1 for compare 2, 2 for counter and 3 for setup. Compare values written read back unchanged. The setup word holds the scale in [3:0], the compare-1 mode in [7:6], the compare-2 mode in [9:8], configured in bit 12, the compare-1 flag in bit 13, the compare-2 flag in bit 14 and counter enable in bit 15. All other setup bits read 0.
- R3: While the counter is enabled and the reference enable is high every cycle, a count tick occurs once every 2^scale reference pulses. Scales 0 through 8 work.
- R4: The counter advances by one per tick while enabled. It holds when disabled or when the reference enable is low. It also holds in any cycle that writes setup or counter.
- R5: With a nonzero compare-2 mode, the counter starts from 0. On the tick that would make it equal compare 2, the compare-2 flag is set and the counter returns to 0. This happens after exactly that many ticks, for compare values from 0x000F to 0xFFFE.
- R6: With a nonzero compare-1 mode, reaching compare 1 sets the compare-1 flag only, and counting continues past it.
- R7: Flags stay set until written with 1. A setup write with enable 0 and both flag bits 1 stops the counter and clears both flags at once.
- R8: Each event output is high exactly while its flag is set and its mode is 3. A flag set under another nonzero mode leaves the event low.
- R9: The first setup write sets configured. Later writes change only enable and clear flags; scale and modes keep their first value until reset.
- R10: Enabling the counter restarts the prescaler, so the first tick after an enable takes a full 2^scale reference pulses.
- R11: Writing the counter register loads its value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference rate enable pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cmp1_evt | output | 1 | Compare-1 event |
| cmp2_evt | output | 1 | Compare-2 event |

## Verification
The assertions assume that a write to any address takes one clock cycle. They also assume that the only writes that change the counter are direct counter loads. The stopped-counter and step checks depend on this. The stimulus drives every write as a single-cycle strobe set up half a period before the edge. It keeps reg_wr low between writes, so a flag can only be cleared by a setup write. For the same reason, a counter jump only follows a counter write or a compare-2 return.

// File: rtl/evtimer.sv
module evtimer #(
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             cmp1_evt,
  output logic             cmp2_evt
);
  localparam int DIV_W = (1 << SCALE_W) - 1;
  localparam logic [1:0] A_CMP1 = 2'd0;
  localparam logic [1:0] A_CMP2 = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_SET  = 2'd3;
  localparam int B_CFG = 12;
  localparam int B_F1  = 13;
  localparam int B_F2  = 14;
  localparam int B_EN  = 15;

  logic [CNT_W-1:0]   cmp1_q, cmp2_q, cnt_q, cnt_nxt;
  logic [SCALE_W-1:0] scale_q;
  logic [1:0]         mode1_q, mode2_q;
  logic               en_q, flag1_q, flag2_q, cfg_q;
  logic [DIV_W-1:0]   pre_q, pre_mask;
  logic               wr_set, wr_cnt, run, tick, hit1, hit2;

  assign wr_set   = reg_wr && reg_addr == A_SET;
  assign wr_cnt   = reg_wr && reg_addr == A_CNT;
  assign run      = en_q && !wr_set && !wr_cnt;
  assign pre_mask = ~({DIV_W{1'b1}} << scale_q);
  assign tick     = run && ref_tick && ((pre_q & pre_mask) == pre_mask);
  assign cnt_nxt  = cnt_q + 1'b1;
  assign hit1     = tick && mode1_q != 2'd0 && cnt_nxt == cmp1_q;
  assign hit2     = tick && mode2_q != 2'd0 && cnt_nxt == cmp2_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                pre_q <= '0;
    else if (!en_q)            pre_q <= '0;
    else if (run && ref_tick)  pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= reg_wdata;
    else if (hit2)    cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CMP1) cmp1_q <= reg_wdata;
      if (reg_addr == A_CMP2) cmp2_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      mode1_q <= '0;
      mode2_q <= '0;
      cfg_q   <= 1'b0;
      en_q    <= 1'b0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      if (wr_set) begin
        en_q <= reg_wdata[B_EN];
        if (!cfg_q) begin
          scale_q <= reg_wdata[SCALE_W-1:0];
          mode1_q <= reg_wdata[7:6];
          mode2_q <= reg_wdata[9:8];
          cfg_q   <= 1'b1;
        end
      end
      flag1_q <= (flag1_q && !(wr_set && reg_wdata[B_F1])) || hit1;
      flag2_q <= (flag2_q && !(wr_set && reg_wdata[B_F2])) || hit2;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMP1: reg_rdata = cmp1_q;
      A_CMP2: reg_rdata = cmp2_q;
      A_CNT:  reg_rdata = cnt_q;
      default: begin
        reg_rdata[SCALE_W-1:0] = scale_q;
        reg_rdata[7:6]  = mode1_q;
        reg_rdata[9:8]  = mode2_q;
        reg_rdata[B_CFG] = cfg_q;
        reg_rdata[B_F1]  = flag1_q;
        reg_rdata[B_F2]  = flag2_q;
        reg_rdata[B_EN]  = en_q;
      end
    endcase
  end

  assign cmp1_evt = flag1_q && mode1_q == 2'd3;
  assign cmp2_evt = flag2_q && mode2_q == 2'd3;
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] cnt_q,
  input logic [3:0]  scale_q,
  input logic [1:0]  mode1_q,
  input logic [1:0]  mode2_q,
  input logic        en_q,
  input logic        cfg_q,
  input logic        flag2_q,
  input logic        cmp2_evt
);
  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(reg_wr && reg_addr == 2'd2)) |=> cnt_q == $past(cnt_q));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd2) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1 || cnt_q == 16'd0));

  // R9
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |=> ($stable(scale_q) && $stable(mode1_q) && $stable(mode2_q) && cfg_q));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[14]) |=> !flag2_q);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2_q && !(reg_wr && reg_addr == 2'd3)) |=> flag2_q);

  // R8
  evt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp2_evt |-> (flag2_q && mode2_q == 2'd3));
endmodule

bind evtimer evtimer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cnt_q(cnt_q), .scale_q(scale_q),
  .mode1_q(mode1_q), .mode2_q(mode2_q), .en_q(en_q), .cfg_q(cfg_q),
  .flag2_q(flag2_q), .cmp2_evt(cmp2_evt)
);

// File: tb/test_evtimer.sv
module test_evtimer;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic cmp1_evt, cmp2_evt;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  evtimer i_evtimer (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp1_evt(cmp1_evt), .cmp2_evt(cmp2_evt));

  function automatic logic [15:0] sw(bit en, bit f2, bit f1, logic [1:0] m2, logic [1:0] m1, logic [3:0] sc);
    return {en, f2, f1, 3'b000, m2, m1, 2'b00, sc};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b1; reg_wr = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register after reset", v, 0);
    end
    check("R1 events after reset", {cmp1_evt, cmp2_evt}, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    do_reset();
    wr(2'd0, 16'h1234); wr(2'd1, 16'hBEEF); wr(2'd2, 16'h0055);
    rd(2'd0, v); check("R2 compare 1 readback", v, 16'h1234);
    rd(2'd1, v); check("R2 compare 2 readback", v, 16'hBEEF);
    wait_n(3);
    rd(2'd2, v); check("R11 counter load", v, 16'h0055);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd1, 2'd2, 4'd3));
    rd(2'd3, v); check("R9 first setup write", v, 16'h1000 | sw(0, 0, 0, 2'd1, 2'd2, 4'd3));
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd0, 4'd5));
    rd(2'd3, v); check("R9 fields locked", v, 16'h1000 | sw(0, 0, 0, 2'd1, 2'd2, 4'd3));
  endtask

  task automatic t_cmp2_min();
    logic [15:0] v, h;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd0, 4'd0));
    wr(2'd1, 16'h000F); wr(2'd2, 16'h0000);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(14);
    rd(2'd2, v); check("R4 counter after 14 ticks", v, 14);
    rd(2'd3, v); check("R5 no flag before match", v[14], 0);
    wait_n(1);
    rd(2'd3, v); check("R5 flag at 15 ticks", v[14], 1);
    rd(2'd2, v); check("R5 counter returns to 0", v, 0);
    check("R8 cmp2 event high in mode 3", cmp2_evt, 1);
    ref_tick = 1'b0;
    rd(2'd2, h); wait_n(5); rd(2'd2, v);
    check("R4 hold without reference pulse", v, h);
    ref_tick = 1'b1;
    wait_n(20);
    rd(2'd3, v); check("R7 flag sticky", v[14], 1);
    wr(2'd3, sw(1, 1, 0, 2'd0, 2'd0, 4'd0));
    rd(2'd3, v); check("R7 flag cleared, still enabled", {v[15], v[14]}, 2'b10);
    check("R8 event low after clear", cmp2_evt, 0);
  endtask

  task automatic t_cmp1();
    logic [15:0] v, h;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd3, 4'd0));
    wr(2'd0, 16'd5); wr(2'd1, 16'd20); wr(2'd2, 16'd0);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(5);
    rd(2'd3, v); check("R6 flag 1 set, flag 2 clear", {v[14], v[13]}, 2'b01);
    check("R8 cmp1 event", cmp1_evt, 1);
    wait_n(2);
    rd(2'd2, v); check("R6 counting continues past compare 1", v, 7);
    wait_n(13);
    rd(2'd3, v); check("R5 flag 2 at compare 2", {v[14], v[13]}, 2'b11);
    wr(2'd3, sw(0, 1, 1, 2'd0, 2'd0, 4'd0));
    rd(2'd3, v); check("R7 stop and clear both", {v[15], v[14], v[13]}, 3'b000);
    check("R7 events low", {cmp1_evt, cmp2_evt}, 0);
    rd(2'd2, h); wait_n(4); rd(2'd2, v);
    check("R7 counter stopped", v, h);
  endtask

  task automatic t_mode1();
    logic [15:0] v;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd1, 2'd0, 4'd0));
    wr(2'd1, 16'h000F); wr(2'd2, 16'd0);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(15);
    rd(2'd3, v); check("R5 flag in mode 1", v[14], 1);
    rd(2'd2, v); check("R5 counter reset in mode 1", v, 0);
    check("R8 no event in mode 1", cmp2_evt, 0);
  endtask

  task automatic t_scale2();
    logic [15:0] v;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd0, 4'd2));
    wr(2'd1, 16'd4); wr(2'd2, 16'd0);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(15);
    rd(2'd2, v); check("R3 scale 2 count after 15 pulses", v, 3);
    rd(2'd3, v); check("R3 scale 2 no flag yet", v[14], 0);
    wait_n(1);
    rd(2'd3, v); check("R3 scale 2 match at 16 pulses", v[14], 1);
    wr(2'd3, sw(1, 1, 0, 2'd0, 2'd0, 4'd0));
    wait_n(2);
    wr(2'd3, sw(0, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(2);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(3);
    rd(2'd2, v); check("R10 no tick before full period", v, 0);
    wait_n(1);
    rd(2'd2, v); check("R10 first tick after full period", v, 1);
  endtask

  task automatic t_scale8();
    logic [15:0] v;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd0, 4'd8));
    wr(2'd1, 16'h000F); wr(2'd2, 16'd0);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(3839);
    rd(2'd3, v); check("R3 scale 8 no flag early", v[14], 0);
    wait_n(1);
    rd(2'd3, v); check("R3 scale 8 match at 3840 pulses", v[14], 1);
  endtask

  task automatic t_max();
    logic [15:0] v;
    do_reset();
    wr(2'd3, sw(0, 0, 0, 2'd3, 2'd0, 4'd0));
    wr(2'd1, 16'hFFFE); wr(2'd2, 16'd0);
    wr(2'd3, sw(1, 0, 0, 2'd0, 2'd0, 4'd0));
    wait_n(65533);
    rd(2'd2, v); check("R5 counter before largest compare", v, 16'hFFFD);
    rd(2'd3, v); check("R5 no flag before largest compare", v[14], 0);
    wait_n(1);
    rd(2'd3, v); check("R5 flag at largest compare", v[14], 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset(); t_regs(); t_lock(); t_cmp2_min(); t_cmp1();
    t_mode1(); t_scale2(); t_scale8(); t_max();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule